// File: doc/BRIEF.md
# Receiver Offset Tuning Enable Controller

This block decides when the receive-only frequency offset of a transceiver is in force. An operator button turns the offset on and off, and each button press flips the state. Any step of the main tuning encoder turns the offset off. While the radio transmits, the synthesizer is always told to use the fixed frequency. The stored enable state is kept through transmit, so the offset returns as soon as the radio goes back to receive.

The raw button line is brought into the clock domain by a two-flop synchronizer. It must then hold a new level for a set number of cycles before that level is accepted. Only a rising edge of the accepted level counts as a press. The transmit/receive line passes through its own synchronizer. The tuning step input is a single-cycle strobe that is already synchronous to the clock. Two outputs are provided. One drives an indicator LED. The other is a registered select line that tells the synthesizer whether to use the variable offset path or the fixed path.

Top module: `rit_enable_ctrl`

## Requirements
- R1: Each accepted button press flips the enable state: off becomes on, and on becomes off.
- R2: A new button level takes effect only after it has stayed unchanged for STABLE_CYCLES consecutive clock cycles (default 16). Shorter pulses and contact chatter cause no toggle, so one physical press gives exactly one toggle.
- R3: A tuning step strobe (`tune_step_i` = 1) sets the enable state to off, whatever its value was before.
- R4: In receive mode (`tx_mode_i` = 0) with the offset enabled, `vxo_var_sel_o` is 1, which selects the variable path.
- R5: In transmit mode (`tx_mode_i` = 1), `vxo_var_sel_o` is 0, which selects the fixed path, even when the offset is enabled.
- R6: Transmit mode does not change the enable state. After the return to receive, `vxo_var_sel_o` goes back to 1 if the offset is still enabled.
- R7: `rit_led_o` equals the enable state.
- R8: Releasing the button, which is a falling edge of the accepted level, does not toggle the enable state.
- R9: If a press and a tuning strobe arrive in the same cycle, the enable state ends up off.
- R10: After reset, `rit_led_o` is 0 and `vxo_var_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw_i | input | 1 | Raw offset button level, asynchronous, 1 = pressed |
| tune_step_i | input | 1 | Tuning encoder step strobe, synchronous, one cycle per step |
| tx_mode_i | input | 1 | Raw mode line, asynchronous, 1 = transmit, 0 = receive |
| rit_led_o | output | 1 | Offset enable indicator, 1 = on |
| vxo_var_sel_o | output | 1 | Synthesizer select, 1 = variable offset path, 0 = fixed path |

## Verification
The assertions take two things for granted about the inputs. The tuning strobe is synchronous to the clock. The button and mode lines are observed only after their synchronizers, so every property is stated on the synchronized mode, the internal press pulse and the registered outputs. The stimulus changes the raw lines only on the falling clock edge. It holds each button level well beyond STABLE_CYCLES, except in the glitch and chatter scenarios, which use deliberately short pulses. For the same-cycle conflict, the tuning strobe is kept high for a window of cycles that surely contains the press pulse, so the bench does not have to predict the exact cycle of that pulse.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int unsigned DEF_STABLE_CYCLES = 16;
  localparam int unsigned DEF_SYNC_STAGES   = 2;
  localparam logic SEL_FIXED    = 1'b0;
  localparam logic SEL_VARIABLE = 1'b1;
endpackage

// File: rtl/rit_sync.sv
module rit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rit_debounce.sv
module rit_debounce #(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic press_o
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          stable_q;
  logic          press_q;
  logic          accept;

  assign accept = (level_i != stable_q) && (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      press_q  <= 1'b0;
    end else begin
      press_q <= accept && level_i;
      if (level_i == stable_q) begin
        cnt_q <= '0;
      end else if (accept) begin
        stable_q <= level_i;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/rit_latch.sv
module rit_latch (
  input  logic clk,
  input  logic rst,
  input  logic press_i,
  input  logic clear_i,
  input  logic tx_i,
  output logic enable_o,
  output logic var_sel_o
);
  import rit_pkg::*;

  logic enable_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      sel_q    <= SEL_FIXED;
    end else begin
      if (clear_i)      enable_q <= 1'b0;
      else if (press_i) enable_q <= ~enable_q;
      sel_q <= (enable_q && !tx_i) ? SEL_VARIABLE : SEL_FIXED;
    end
  end

  assign enable_o  = enable_q;
  assign var_sel_o = sel_q;
endmodule

// File: rtl/rit_enable_ctrl.sv
module rit_enable_ctrl #(
  parameter int unsigned STABLE_CYCLES = rit_pkg::DEF_STABLE_CYCLES,
  parameter int unsigned SYNC_STAGES   = rit_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw_i,
  input  logic tune_step_i,
  input  logic tx_mode_i,
  output logic rit_led_o,
  output logic vxo_var_sel_o
);
  logic btn_s;
  logic tx_s;
  logic press;

  rit_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
    .clk(clk), .rst(rst), .d_i(btn_raw_i), .q_o(btn_s)
  );

  rit_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(clk), .rst(rst), .d_i(tx_mode_i), .q_o(tx_s)
  );

  rit_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_deb (
    .clk(clk), .rst(rst), .level_i(btn_s), .press_o(press)
  );

  rit_latch u_latch (
    .clk(clk), .rst(rst), .press_i(press), .clear_i(tune_step_i),
    .tx_i(tx_s), .enable_o(rit_led_o), .var_sel_o(vxo_var_sel_o)
  );
endmodule

// File: rtl/rit_enable_ctrl_chk.sv
module rit_enable_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tune_step_i,
  input logic tx_s,
  input logic press,
  input logic rit_led_o,
  input logic vxo_var_sel_o
);
  // R1: a press without a strobe flips the state
  a_r1_press_toggles: assert property (@(posedge clk) disable iff (rst)
    (press && !tune_step_i) |=> (rit_led_o != $past(rit_led_o)));

  // R2: an accepted press is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  // R3 and R9: a strobe always leaves the state off
  a_r3_tune_clears: assert property (@(posedge clk) disable iff (rst)
    tune_step_i |=> !rit_led_o);

  // R4: the variable path is chosen only when the state was on
  a_r4_var_needs_enable: assert property (@(posedge clk) disable iff (rst)
    vxo_var_sel_o |-> $past(rit_led_o));

  // R5: transmit forces the fixed path
  a_r5_tx_fixed: assert property (@(posedge clk) disable iff (rst)
    tx_s |=> !vxo_var_sel_o);

  // R6: without a press or a strobe the state holds, transmit included
  a_r6_state_holds: assert property (@(posedge clk) disable iff (rst)
    (!press && !tune_step_i) |=> $stable(rit_led_o));
endmodule

bind rit_enable_ctrl rit_enable_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .tune_step_i(tune_step_i), .tx_s(tx_s),
  .press(press), .rit_led_o(rit_led_o), .vxo_var_sel_o(vxo_var_sel_o)
);

// File: tb/tb_rit_enable_ctrl.sv
module tb_rit_enable_ctrl;
  localparam int STABLE = 16;
  localparam int SETTLE = STABLE + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic tune = 1'b0;
  logic tx = 1'b0;
  logic led;
  logic sel;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rit_enable_ctrl #(.STABLE_CYCLES(STABLE)) dut (
    .clk(clk), .rst(rst), .btn_raw_i(btn), .tune_step_i(tune),
    .tx_mode_i(tx), .rit_led_o(led), .vxo_var_sel_o(sel)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic press_clean();
    btn = 1'b1; wait_cyc(SETTLE);
    btn = 1'b0; wait_cyc(SETTLE);
  endtask

  task automatic t_reset();
    rst = 1'b1; btn = 1'b0; tune = 1'b0; tx = 1'b0;
    wait_cyc(3);
    rst = 1'b0; wait_cyc(2);
    check("R10 led after reset", led, 1'b0);
    check("R10 sel after reset", sel, 1'b0);
  endtask

  task automatic t_toggle();
    btn = 1'b1; wait_cyc(SETTLE);
    check("R1 first press on", led, 1'b1);
    check("R7 led shows state", led, 1'b1);
    check("R4 rx with offset selects variable", sel, 1'b1);
    btn = 1'b0; wait_cyc(SETTLE);
    check("R8 release keeps state", led, 1'b1);
    press_clean();
    check("R1 second press off", led, 1'b0);
    check("R4 offset off selects fixed", sel, 1'b0);
  endtask

  task automatic t_glitch();
    btn = 1'b1; wait_cyc(STABLE - 4);
    btn = 1'b0; wait_cyc(SETTLE);
    check("R2 short pulse ignored", led, 1'b0);
  endtask

  task automatic t_chatter();
    for (int k = 0; k < 12; k++) begin
      btn = ~btn; wait_cyc(3);
    end
    btn = 1'b1; wait_cyc(SETTLE);
    for (int k = 0; k < 8; k++) begin
      btn = ~btn; wait_cyc(2);
    end
    btn = 1'b0; wait_cyc(SETTLE);
    check("R2 chatter gives one toggle", led, 1'b1);
  endtask

  task automatic t_tune();
    tune = 1'b1; wait_cyc(1); tune = 1'b0; wait_cyc(2);
    check("R3 strobe clears on state", led, 1'b0);
    tune = 1'b1; wait_cyc(1); tune = 1'b0; wait_cyc(2);
    check("R3 strobe keeps off state off", led, 1'b0);
  endtask

  task automatic t_tx();
    press_clean();
    check("R1 enable before tx", led, 1'b1);
    tx = 1'b1; wait_cyc(6);
    check("R5 tx selects fixed", sel, 1'b0);
    check("R6 tx keeps state", led, 1'b1);
    tx = 1'b0; wait_cyc(6);
    check("R6 return restores variable", sel, 1'b1);
    tx = 1'b1; wait_cyc(6);
    tune = 1'b1; wait_cyc(1); tune = 1'b0;
    tx = 1'b0; wait_cyc(6);
    check("R3 strobe in tx clears", led, 1'b0);
    check("R6 cleared state stays fixed", sel, 1'b0);
  endtask

  task automatic t_conflict();
    btn = 1'b1;
    wait_cyc(STABLE - 4);
    tune = 1'b1; wait_cyc(10); tune = 1'b0;
    wait_cyc(4);
    check("R9 strobe wins over press", led, 1'b0);
    btn = 1'b0; wait_cyc(SETTLE);
    check("R9 still off after release", led, 1'b0);
  endtask

  initial begin
    t_reset();
    t_toggle();
    t_glitch();
    t_chatter();
    t_tune();
    t_tx();
    t_conflict();
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule